// File: doc/BRIEF.md
# Debug Register Write Command Handler

This block is the receiving end of a word-oriented background-debug command channel. It handles only the command that writes one debug register. A shift interface outside the block moves one 16-bit word per exchange and tells the handler with a one-cycle `xfer_valid` pulse. At the same moment, the interface shifts out the handler's current 17-bit response word, so every exchange carries back the status of the step before it.

A legal command word names a register index. After it come two operand words, the upper half of the value first. Once both halves have arrived, the handler waits `WR_LAT` cycles to model the time the write takes. It then raises a single-cycle write strobe with the index and the 32-bit value, and updates its register bank, which drives the breakpoint logic through `bank_flat`. The response shifted out in the next command slot is the complete code. If that slot arrives while the write is still pending, it returns not-ready instead. A word that does not decode as the command is answered with the illegal code.

Top module: `dbg_wreg_handler`

## Requirements
- R1: After a synchronous reset, `xfer_tx` is 0x0FFFF, `wr_stb` is low, every register in the bank reads zero, and the handler waits for a command word.
- R2: While waiting for a command, a word with 0x2 in bits 15:12, 0xC in bits 11:8, 1 in bit 7 and 00 in bits 6:5 is legal. Its bits 4:0 are the register index, and the response after it is not-ready (0x10000).
- R3: While waiting for a command, any other word leaves the handler waiting and sets the response to illegal (0x1FFFF).
- R4: The two exchanges after a legal command carry data bits 31:16 and then bits 15:0. The response after each of them is not-ready.
- R5: `wr_stb` is high for exactly one cycle, exactly `WR_LAT` clock edges after the edge that took the low data word. It is accompanied by the index and the assembled 32-bit value.
- R6: While the write is pending, the response is not-ready. At the edge that raises `wr_stb`, it becomes complete (0x0FFFF). Bit 16 of every response is the status flag.
- R7: Words exchanged while a write is pending are discarded. They neither start a command nor change the pending write.
- R8: A write to an index below `NREG` replaces that bank register and leaves the others unchanged. A write to any higher index still strobes and completes, but leaves the whole bank unchanged.
- R9: A synchronous reset in the middle of a command abandons it without a strobe. The next word is decoded as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| xfer_valid | input | 1 | One-cycle pulse marking a completed word exchange |
| xfer_rx | input | 16 | Word received in this exchange |
| xfer_tx | output | 17 | Response word to shift out in the next exchange; bit 16 is the status flag |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_idx | output | 5 | Register index of the write |
| wr_data | output | 32 | Value of the write |
| bank_flat | output | NREG*32 | Debug register contents, register i at bits i*32 +: 32 |

## Verification
The bench targets near-miss command words: a wrong upper nibble, a clear bit 7, or nonzero bits 6:5. A decoder that checked too few bits would accept these and answer not-ready instead of illegal. It sends a command word back-to-back with the low data word, while the write is pending. A handler that kept decoding during that window would start a second command, and the word that follows would then be taken as data instead of being rejected as illegal. It also writes to an unimplemented index and resets halfway through a command. A bank that aliased high indices would corrupt a live register, and a handler that kept state across reset would issue a stray strobe.

// File: rtl/dbg_wreg_pkg.sv
package dbg_wreg_pkg;
    localparam int WORD_W = 16;
    localparam int DATA_W = 2 * WORD_W;
    localparam int RESP_W = WORD_W + 1;
    localparam int IDX_W  = 5;

    localparam logic [3:0] OPC_HI_NIB = 4'h2;
    localparam logic [3:0] OPC_LO_NIB = 4'hC;

    localparam logic [RESP_W-1:0] RESP_NOT_READY = 17'h1_0000;
    localparam logic [RESP_W-1:0] RESP_ILLEGAL   = 17'h1_FFFF;
    localparam logic [RESP_W-1:0] RESP_DONE      = 17'h0_FFFF;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DHI  = 2'd1,
        ST_DLO  = 2'd2,
        ST_BUSY = 2'd3
    } hst_e;

    typedef struct packed {
        hst_e              st;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] hi;
        logic [DATA_W-1:0] data;
        logic [RESP_W-1:0] resp;
        logic              stb;
    } hstate_t;
endpackage

// File: rtl/dbg_wreg_decode.sv
module dbg_wreg_decode
    import dbg_wreg_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic              legal,
    output logic [IDX_W-1:0]  idx
);
    always_comb begin
        legal = (word[15:12] == OPC_HI_NIB) &&
                (word[11:8]  == OPC_LO_NIB) &&
                word[7] &&
                (word[6:5] == 2'b00);
        idx   = word[IDX_W-1:0];
    end
endmodule

// File: rtl/dbg_wreg_timer.sv
module dbg_wreg_timer #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic done
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(LAT);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == CW'(1));
endmodule

// File: rtl/dbg_wreg_bank.sv
module dbg_wreg_bank #(
    parameter int NREG = 8,
    parameter int DW   = 32,
    parameter int IW   = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IW-1:0]    widx,
    input  logic [DW-1:0]    wdata,
    output logic [NREG*DW-1:0] flat
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [DW-1:0] r_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                r_q <= '0;
            end else if (we && (widx == IW'(i))) begin
                r_q <= wdata;
            end
        end
        assign flat[i*DW +: DW] = r_q;
    end
endmodule

// File: rtl/dbg_wreg_handler.sv
module dbg_wreg_handler
    import dbg_wreg_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int WR_LAT = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   xfer_valid,
    input  logic [WORD_W-1:0]      xfer_rx,
    output logic [RESP_W-1:0]      xfer_tx,
    output logic                   wr_stb,
    output logic [IDX_W-1:0]       wr_idx,
    output logic [DATA_W-1:0]      wr_data,
    output logic [NREG*DATA_W-1:0] bank_flat
);
    localparam hstate_t RST_STATE = '{
        st:   ST_IDLE,
        idx:  '0,
        hi:   '0,
        data: '0,
        resp: RESP_DONE,
        stb:  1'b0
    };

    hstate_t s_d, s_q;
    logic             cmd_ok;
    logic [IDX_W-1:0] cmd_idx;
    logic             tmr_start;
    logic             tmr_done;
    logic             in_idle;
    logic             in_busy;

    dbg_wreg_decode u_dec (
        .word  (xfer_rx),
        .legal (cmd_ok),
        .idx   (cmd_idx)
    );

    dbg_wreg_timer #(.LAT(WR_LAT)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (tmr_start),
        .done  (tmr_done)
    );

    always_comb begin
        s_d       = s_q;
        s_d.stb   = 1'b0;
        tmr_start = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (xfer_valid) begin
                    if (cmd_ok) begin
                        s_d.idx  = cmd_idx;
                        s_d.st   = ST_DHI;
                        s_d.resp = RESP_NOT_READY;
                    end else begin
                        s_d.resp = RESP_ILLEGAL;
                    end
                end
            end
            ST_DHI: begin
                if (xfer_valid) begin
                    s_d.hi   = xfer_rx;
                    s_d.st   = ST_DLO;
                    s_d.resp = RESP_NOT_READY;
                end
            end
            ST_DLO: begin
                if (xfer_valid) begin
                    s_d.data  = {s_q.hi, xfer_rx};
                    s_d.st    = ST_BUSY;
                    s_d.resp  = RESP_NOT_READY;
                    tmr_start = 1'b1;
                end
            end
            ST_BUSY: begin
                // exchanges in this state are dropped on purpose
                if (tmr_done) begin
                    s_d.stb  = 1'b1;
                    s_d.st   = ST_IDLE;
                    s_d.resp = RESP_DONE;
                end
            end
            default: s_d = RST_STATE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= RST_STATE;
        end else begin
            s_q <= s_d;
        end
    end

    dbg_wreg_bank #(.NREG(NREG), .DW(DATA_W), .IW(IDX_W)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (s_d.stb),
        .widx  (s_d.idx),
        .wdata (s_d.data),
        .flat  (bank_flat)
    );

    assign xfer_tx = s_q.resp;
    assign wr_stb  = s_q.stb;
    assign wr_idx  = s_q.idx;
    assign wr_data = s_q.data;
    assign in_idle = (s_q.st == ST_IDLE);
    assign in_busy = (s_q.st == ST_BUSY);
endmodule

module dbg_wreg_checker
    import dbg_wreg_pkg::*;
#(
    parameter int NREG = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   xfer_valid,
    input logic [RESP_W-1:0]      xfer_tx,
    input logic                   wr_stb,
    input logic [IDX_W-1:0]       wr_idx,
    input logic [DATA_W-1:0]      wr_data,
    input logic [NREG*DATA_W-1:0] bank_flat,
    input logic                   in_idle,
    input logic                   in_busy,
    input logic                   cmd_ok
);
    a_r2_cmd_not_ready: assert property (@(posedge clk) disable iff (rst)
        (in_idle && xfer_valid && cmd_ok) |=> (xfer_tx == RESP_NOT_READY && !in_idle));

    a_r3_illegal_stays_idle: assert property (@(posedge clk) disable iff (rst)
        (in_idle && xfer_valid && !cmd_ok) |=> (xfer_tx == RESP_ILLEGAL && in_idle));

    a_r5_stb_single: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    a_r5_stb_after_busy: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> $past(in_busy));

    a_r6_done_with_stb: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> (xfer_tx == RESP_DONE && in_idle));

    a_r6_pending_not_ready: assert property (@(posedge clk) disable iff (rst)
        in_busy |-> (xfer_tx == RESP_NOT_READY));

    a_r7_busy_data_stable: assert property (@(posedge clk) disable iff (rst)
        (in_busy && !wr_stb) |=> $stable(wr_data));

    a_r8_bank_written: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && (int'(wr_idx) < NREG)) |-> (bank_flat[wr_idx*DATA_W +: DATA_W] == wr_data));
endmodule

bind dbg_wreg_handler dbg_wreg_checker #(.NREG(NREG)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .xfer_valid (xfer_valid),
    .xfer_tx    (xfer_tx),
    .wr_stb     (wr_stb),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .bank_flat  (bank_flat),
    .in_idle    (in_idle),
    .in_busy    (in_busy),
    .cmd_ok     (cmd_ok)
);

// File: tb/tb_dbg_wreg_handler.sv
module tb_dbg_wreg_handler;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 8;
    localparam int LAT  = 2;
    localparam logic [16:0] NR = 17'h1_0000;
    localparam logic [16:0] IL = 17'h1_FFFF;
    localparam logic [16:0] DN = 17'h0_FFFF;

    typedef struct packed {
        logic [15:0] w;
        logic [16:0] now;
        logic [16:0] later;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{16'h2C83, NR, NR, 4'd2},
        '{16'h1234, NR, NR, 4'd4},
        '{16'h5678, NR, DN, 4'd6},
        '{16'h3C83, IL, IL, 4'd3},
        '{16'h2C03, IL, IL, 4'd3},
        '{16'h2CA3, IL, IL, 4'd3},
        '{16'h2C80, NR, NR, 4'd2},
        '{16'hFFFF, NR, NR, 4'd4},
        '{16'h0001, NR, DN, 4'd6},
        '{16'h2C87, NR, NR, 4'd2},
        '{16'hA5A5, NR, NR, 4'd4},
        '{16'h5A5A, NR, DN, 4'd6}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic xfer_valid = 1'b0;
    logic [15:0] xfer_rx = '0;
    logic [16:0] xfer_tx;
    logic wr_stb;
    logic [4:0] wr_idx;
    logic [31:0] wr_data;
    logic [NREG*32-1:0] bank_flat;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int stb_cnt = 0;
    int stb_cyc = 0;
    int lo_cyc  = 0;
    logic [4:0]  stb_idx;
    logic [31:0] stb_data;
    logic [NREG*32-1:0] snap;
    bit done = 1'b0;

    dbg_wreg_handler #(.NREG(NREG), .WR_LAT(LAT)) dut (
        .clk(clk), .rst(rst), .xfer_valid(xfer_valid), .xfer_rx(xfer_rx),
        .xfer_tx(xfer_tx), .wr_stb(wr_stb), .wr_idx(wr_idx),
        .wr_data(wr_data), .bank_flat(bank_flat)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (wr_stb) begin
            stb_cnt  = stb_cnt + 1;
            stb_cyc  = cyc;
            stb_idx  = wr_idx;
            stb_data = wr_data;
        end
    end

    function automatic logic [31:0] reg_at(input int i);
        return bank_flat[i*32 +: 32];
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge, after the capturing edge
    task automatic xchg(input logic [15:0] w);
        xfer_valid = 1'b1;
        xfer_rx    = w;
        @(negedge clk);
        xfer_valid = 1'b0;
        xfer_rx    = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 resp", 64'(xfer_tx), 64'(DN));
        chk("R1 stb", 64'(wr_stb), 64'd0);
        chk("R1 bank", 64'(bank_flat == '0), 64'd1);

        // vector table
        for (int v = 0; v < NV; v++) begin
            xchg(VECS[v].w);
            chk($sformatf("R%0d now v%0d", VECS[v].req, v), 64'(xfer_tx), 64'(VECS[v].now));
            idle(4);
            chk($sformatf("R%0d later v%0d", VECS[v].req, v), 64'(xfer_tx), 64'(VECS[v].later));
        end
        chk("R2 R8 reg3", 64'(reg_at(3)), 64'h1234_5678);
        chk("R4 R8 reg0", 64'(reg_at(0)), 64'hFFFF_0001);
        chk("R8 reg7", 64'(reg_at(7)), 64'hA5A5_5A5A);
        chk("R8 reg5 untouched", 64'(reg_at(5)), 64'd0);
        chk("R5 strobe count", 64'(stb_cnt), 64'd3);

        // R5: strobe timing and payload
        base = stb_cnt;
        xchg(16'h2C85); xchg(16'hDEAD); xchg(16'hBEEF);
        lo_cyc = cyc;
        chk("R6 pending", 64'(xfer_tx), 64'(NR));
        idle(LAT + 3);
        chk("R5 one pulse", 64'(stb_cnt - base), 64'd1);
        chk("R5 latency", 64'(stb_cyc - lo_cyc), 64'(LAT));
        chk("R5 idx", 64'(stb_idx), 64'd5);
        chk("R5 data", 64'(stb_data), 64'hDEAD_BEEF);
        chk("R6 done", 64'(xfer_tx), 64'(DN));

        // R7: word during pending write is dropped
        xchg(16'h2C81); xchg(16'h1111); xchg(16'h2222);
        xchg(16'h2C82);
        chk("R7 busy resp", 64'(xfer_tx), 64'(NR));
        idle(4);
        chk("R7 done", 64'(xfer_tx), 64'(DN));
        chk("R7 reg1", 64'(reg_at(1)), 64'h1111_2222);
        chk("R7 reg2 untouched", 64'(reg_at(2)), 64'd0);
        xchg(16'h1234);
        chk("R7 next word is command slot", 64'(xfer_tx), 64'(IL));

        // R8: unimplemented index
        snap = bank_flat;
        base = stb_cnt;
        xchg(16'h2C94); xchg(16'hCAFE); xchg(16'hF00D);
        idle(4);
        chk("R8 high idx done", 64'(xfer_tx), 64'(DN));
        chk("R8 high idx strobe", 64'(stb_cnt - base), 64'd1);
        chk("R8 high idx index", 64'(stb_idx), 64'd20);
        chk("R8 bank unchanged", 64'(bank_flat == snap), 64'd1);

        // R9: reset mid-command
        base = stb_cnt;
        xchg(16'h2C84); xchg(16'h4444);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 resp after reset", 64'(xfer_tx), 64'(DN));
        xchg(16'h4444);
        chk("R9 decoded as command", 64'(xfer_tx), 64'(IL));
        idle(5);
        chk("R9 no strobe", 64'(stb_cnt - base), 64'd0);
        chk("R9 R1 bank cleared", 64'(bank_flat == '0), 64'd1);

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule